// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single down-counter with a word-addressed register port. Software programs a reload value, picks a mode (free-running, periodic or one-shot), a counter width of 16 or 32 bits and a prescale ratio of 1, 16 or 256, then sets the run bit. The `tick_en` input stands in for the timer clock: every cycle it is high counts as one timer clock.

When the counter steps down to zero, a sticky raw flag is set. The interrupt line is that flag gated by an enable bit. Software acknowledges the interrupt by writing any value to the clear slot.

There are two ways to set the reload value. The immediate slot also restarts the count from the new value. The deferred slot only replaces the value used at the next natural reload.

Top module: `interval_timer`

## Requirements
- R1: After reset the mode register reads 0x20, the count reads 0x0000FFFF, both reload slots read 0, raw and masked status read 0 and `irq` is low.
- R2: Byte offsets: 0x00 immediate reload, 0x04 count (read-only), 0x08 mode, 0x0C interrupt clear (write-only, reads 0), 0x10 raw status, 0x14 masked status, 0x18 deferred reload. Both reload slots read the same reload value. Any other offset, including one that is not a multiple of four, reads 0, and writes to it change nothing. Writes to 0x04 are ignored.
- R3: Mode register fields: bit 0 one-shot, bit 1 32-bit width, bits 3:2 prescale, bit 5 interrupt enable, bit 6 periodic, bit 7 run. Bits 7:0 read back as written.
- R4: The counter moves only on a prescaled tick, and only while the run bit is set. With run clear it holds its value whatever `tick_en` does.
- R5: Prescale code 00 gives one count per `tick_en` cycle, 01 one count per 16, 10 one count per 256, and 11 one count per cycle. A mode write clears the prescaler and discards any tick in the same cycle.
- R6: A write to 0x00 sets the reload value and loads the counter on the next edge. This takes priority over a tick in the same cycle.
- R7: A write to 0x18 changes the reload value but leaves the count untouched. The new value is used at the next reload.
- R8: With both one-shot and periodic clear (free-running), a tick at zero reloads 0xFFFFFFFF in 32-bit mode or 0xFFFF in 16-bit mode, ignoring the reload value.
- R9: In periodic mode a tick at zero reloads the counter from the reload value.
- R10: In one-shot mode (bit 0 set, even with bit 6 also set) the counter stays at zero on further ticks until 0x00 is written.
- R11: The raw flag sets when a tick steps the counter from 1 to 0. Ticks that leave the counter at zero do not set it. A write to 0x0C clears it, but a set in the same cycle wins.
- R12: The masked status and `irq` both equal the raw flag ANDed with the interrupt enable bit.
- R13: In 16-bit mode only the low 16 bits count and are tested for zero, and the count reads with bits 31:16 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W (8) | Byte offset of the register accessed |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational from registers |
| tick_en | input | 1 | One timer clock per cycle it is high |
| irq | output | 1 | Level interrupt, raw flag gated by the enable |

## Verification
The counter is driven through each mode in turn, all from one running count.
- Periodic, with an immediate and then a deferred reload: this separates a reload that restarts the count from one that waits for zero.
- One-shot with the periodic bit also set: this shows which bit takes precedence and that the counter parks at zero.
- Free-running in both widths: this shows the reload ignores the programmed value and depends on width.

The prescaler is run through each code for exactly one tick short of and one tick past its ratio. A mode rewrite partway through a prescale period shows that the prescaler restarts.

Simultaneous load-and-tick and clear-and-tick cycles pin down the priorities.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    // Prescale selector encoding (mode register bits 3:2)
    typedef enum logic [1:0] {
        PRE_BY1   = 2'b00,
        PRE_BY16  = 2'b01,
        PRE_BY256 = 2'b10,
        PRE_BY1X  = 2'b11
    } tmr_pre_e;

    // Mode register, bit 7 down to bit 0
    typedef struct packed {
        logic     run;       // 7
        logic     periodic;  // 6
        logic     irq_en;    // 5
        logic     spare;     // 4
        tmr_pre_e pre;       // 3:2
        logic     wide;      // 1
        logic     single;    // 0
    } tmr_mode_t;

    localparam logic [7:0] MODE_RESET = 8'h20;

    // Word slots of the register port
    localparam int unsigned SLOT_RELOAD_NOW   = 0;
    localparam int unsigned SLOT_COUNT        = 1;
    localparam int unsigned SLOT_MODE         = 2;
    localparam int unsigned SLOT_ACK          = 3;
    localparam int unsigned SLOT_RAW          = 4;
    localparam int unsigned SLOT_MASKED       = 5;
    localparam int unsigned SLOT_RELOAD_LATER = 6;

endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int unsigned HI_LOG = 8,
    parameter int unsigned LO_LOG = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     restart,
    input  logic     tick_in,
    input  tmr_pre_e pre,
    output logic     tick_out
);
    localparam logic [HI_LOG-1:0] LO_WRAP = {{(HI_LOG-LO_LOG){1'b0}}, {LO_LOG{1'b1}}};
    localparam logic [HI_LOG-1:0] HI_WRAP = {HI_LOG{1'b1}};

    typedef struct packed {
        logic [HI_LOG-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [HI_LOG-1:0] wrap_at;
    logic use_div;
    logic fire;

    always_comb begin
        st_d = st_q;
        case (pre)
            PRE_BY16:  begin use_div = 1'b1; wrap_at = LO_WRAP; end
            PRE_BY256: begin use_div = 1'b1; wrap_at = HI_WRAP; end
            default:   begin use_div = 1'b0; wrap_at = '0;      end
        endcase
        fire = run && tick_in && !restart && (!use_div || st_q.cnt == wrap_at);
        if (restart || !use_div) begin
            st_d.cnt = '0;
        end else if (run && tick_in) begin
            st_d.cnt = (st_q.cnt == wrap_at) ? '0 : st_q.cnt + HI_LOG'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_out = fire;

endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_now,
    input  logic [DATA_W-1:0] load_val,
    input  logic              ack,
    input  logic              wide,
    input  logic              single,
    input  logic              periodic,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count_full,
    output logic [DATA_W-1:0] count_vis,
    output logic              raw
);
    localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              flag;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [DATA_W-1:0] vis;
    logic [DATA_W-1:0] stepped;
    logic [DATA_W-1:0] refill;
    logic hit_zero;

    always_comb begin
        st_d     = st_q;
        hit_zero = 1'b0;
        vis      = wide ? st_q.cnt : (st_q.cnt & NARROW_MASK);
        stepped  = wide ? st_q.cnt - DATA_W'(1)
                        : {st_q.cnt[DATA_W-1:NARROW_W], st_q.cnt[NARROW_W-1:0] - NARROW_W'(1)};
        if (!single && !periodic) refill = wide ? '1 : NARROW_MASK;
        else                      refill = reload_val;

        if (load_now) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (vis == '0) begin
                if (!single) st_d.cnt = refill;
            end else begin
                st_d.cnt = stepped;
                hit_zero = (vis == DATA_W'(1));
            end
        end

        if (ack)      st_d.flag = 1'b0;
        if (hit_zero) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= NARROW_MASK;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_full = st_q.cnt;
    assign count_vis  = vis;
    assign raw        = st_q.flag;

endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count_vis,
    input  logic              raw,
    output tmr_mode_t         mode,
    output logic [DATA_W-1:0] reload,
    output logic              load_now,
    output logic              mode_wr,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_NOW    = WORD_W'(SLOT_RELOAD_NOW);
    localparam logic [WORD_W-1:0] W_COUNT  = WORD_W'(SLOT_COUNT);
    localparam logic [WORD_W-1:0] W_MODE   = WORD_W'(SLOT_MODE);
    localparam logic [WORD_W-1:0] W_ACK    = WORD_W'(SLOT_ACK);
    localparam logic [WORD_W-1:0] W_RAW    = WORD_W'(SLOT_RAW);
    localparam logic [WORD_W-1:0] W_MASKED = WORD_W'(SLOT_MASKED);
    localparam logic [WORD_W-1:0] W_LATER  = WORD_W'(SLOT_RELOAD_LATER);

    typedef struct packed {
        tmr_mode_t         mode;
        logic [DATA_W-1:0] reload;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [WORD_W-1:0] word;
    logic aligned;
    logic wr_hit;

    always_comb begin
        word    = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        wr_hit  = wr_en && aligned;
        st_d    = st_q;
        load_now = 1'b0;
        mode_wr  = 1'b0;
        ack      = 1'b0;
        if (wr_hit) begin
            case (word)
                W_NOW:   begin st_d.reload = wdata; load_now = 1'b1; end
                W_LATER: st_d.reload = wdata;
                W_MODE:  begin st_d.mode = tmr_mode_t'(wdata[7:0]); mode_wr = 1'b1; end
                W_ACK:   ack = 1'b1;
                default: ;
            endcase
        end

        rdata = '0;
        if (aligned) begin
            case (word)
                W_NOW, W_LATER: rdata = st_q.reload;
                W_COUNT:        rdata = count_vis;
                W_MODE:         rdata = {{(DATA_W-8){1'b0}}, st_q.mode};
                W_RAW:          rdata = {{(DATA_W-1){1'b0}}, raw};
                W_MASKED:       rdata = {{(DATA_W-1){1'b0}}, raw & st_q.mode.irq_en};
                default:        rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode   <= tmr_mode_t'(MODE_RESET);
            st_q.reload <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode   = st_q.mode;
    assign reload = st_q.reload;

endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NARROW_W = 16,
    parameter int unsigned PRE_LO   = 4,
    parameter int unsigned PRE_HI   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_en,
    output logic              irq
);
    tmr_mode_t         mode_w;
    logic [DATA_W-1:0] reload_w;
    logic [DATA_W-1:0] count_full_w;
    logic [DATA_W-1:0] count_vis_w;
    logic              load_now_w;
    logic              mode_wr_w;
    logic              ack_w;
    logic              raw_w;
    logic              tick_w;

    tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count_vis(count_vis_w), .raw(raw_w),
        .mode(mode_w), .reload(reload_w), .load_now(load_now_w),
        .mode_wr(mode_wr_w), .ack(ack_w), .rdata(rdata)
    );

    tmr_prescale #(.HI_LOG(PRE_HI), .LO_LOG(PRE_LO)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(mode_w.run), .restart(mode_wr_w),
        .tick_in(tick_en), .pre(mode_w.pre), .tick_out(tick_w)
    );

    tmr_count #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_w),
        .load_now(load_now_w), .load_val(wdata), .ack(ack_w),
        .wide(mode_w.wide), .single(mode_w.single), .periodic(mode_w.periodic),
        .reload_val(reload_w),
        .count_full(count_full_w), .count_vis(count_vis_w), .raw(raw_w)
    );

    assign irq = raw_w & mode_w.irq_en;

endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic              tick,
    input tmr_mode_t         mode,
    input logic [DATA_W-1:0] count_full,
    input logic [DATA_W-1:0] count_vis,
    input logic              raw
);
    localparam int unsigned WORD_W = ADDR_W - 2;
    logic [WORD_W-1:0] word;
    logic aligned, load_hit, mode_hit;

    assign word     = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);
    assign load_hit = wr_en && aligned && word == WORD_W'(SLOT_RELOAD_NOW);
    assign mode_hit = wr_en && aligned && word == WORD_W'(SLOT_MODE);

    assert_load_sets_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_hit |=> count_full == $past(wdata));

    assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_hit) |=> $stable(count_full));

    assert_tick_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> mode.run);

    assert_single_parks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.single && count_vis == '0 && !load_hit && !mode_hit) |=> count_vis == '0);

    assert_flag_from_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(tick));

    assert_masked_matches_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && word == WORD_W'(SLOT_MASKED)) |-> rdata == {{(DATA_W-1){1'b0}}, irq});

    assert_narrow_upper_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.wide && aligned && word == WORD_W'(SLOT_COUNT)) |-> rdata[DATA_W-1:16] == '0);

endmodule

bind interval_timer tmr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_tmr_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .tick(tick_w), .mode(mode_w),
    .count_full(count_full_w), .count_vis(count_vis_w), .raw(raw_w)
);

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;
    localparam logic [7:0] A_NOW = 8'h00, A_CNT = 8'h04, A_MODE = 8'h08, A_ACK = 8'h0C;
    localparam logic [7:0] A_RAW = 8'h10, A_MSK = 8'h14, A_LATER = 8'h18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic tick_en = 1'b0;
    logic irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [32:0] exp_q[$];
    string tag_q[$];
    logic [32:0] item;
    logic [31:0] got;
    string tag;

    always #2.5 clk = ~clk;

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_en(tick_en), .irq(irq)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic t);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; tick_en = t;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic tk(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        addr = a;
        exp_q.push_back({1'b0, e});
        tag_q.push_back(t);
    endtask

    task automatic ck_irq(input logic e, input string t);
        @(negedge clk);
        exp_q.push_back({1'b1, 31'b0, e});
        tag_q.push_back(t);
    endtask

    // monitor: compares queued expectations against the ports
    initial forever begin
        @(negedge clk);
        #1;
        while (exp_q.size() > 0) begin
            item = exp_q.pop_front();
            tag  = tag_q.pop_front();
            got  = item[32] ? {31'b0, irq} : rdata;
            n_run++;
            if (got !== item[31:0]) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", tag, got, item[31:0]);
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_MODE, 32'h20, "R1 mode");
        rd(A_CNT, 32'hFFFF, "R1 count");
        rd(A_NOW, 32'h0, "R1 reload");
        rd(A_LATER, 32'h0, "R1 reload later");
        rd(A_RAW, 32'h0, "R1 raw");
        ck_irq(1'b0, "R1 irq");
        // R4 no counting while stopped
        tk(5);
        rd(A_CNT, 32'hFFFF, "R4 hold when stopped");
        // R6 immediate reload, R2 both slots
        wr(A_NOW, 32'd10, 1'b0);
        rd(A_CNT, 32'd10, "R6 load sets count");
        rd(A_LATER, 32'd10, "R2 later slot mirrors");
        // R2 ignored writes and unmapped reads
        wr(A_CNT, 32'h1234, 1'b0);
        wr(8'h1C, 32'hFFFF_FFFF, 1'b0);
        wr(8'h01, 32'hFFFF_FFFF, 1'b0);
        rd(A_CNT, 32'd10, "R2 count write ignored");
        rd(A_NOW, 32'd10, "R2 unmapped write ignored");
        rd(8'h1C, 32'h0, "R2 unmapped read");
        rd(A_ACK, 32'h0, "R2 clear slot reads zero");
        rd(8'h09, 32'h0, "R2 unaligned read");
        // R3 / R9 periodic 32-bit with irq enable
        wr(A_MODE, 32'hE2, 1'b0);
        rd(A_MODE, 32'hE2, "R3 mode readback");
        tk(3);
        rd(A_CNT, 32'd7, "R4 three ticks");
        tk(7);
        rd(A_CNT, 32'd0, "R9 reaches zero");
        rd(A_RAW, 32'd1, "R11 raw set");
        rd(A_MSK, 32'd1, "R12 masked set");
        ck_irq(1'b1, "R12 irq high");
        tk(1);
        rd(A_CNT, 32'd10, "R9 periodic reload");
        rd(A_RAW, 32'd1, "R11 flag sticky");
        wr(A_ACK, 32'h0, 1'b0);
        rd(A_RAW, 32'd0, "R11 clear");
        ck_irq(1'b0, "R12 irq low after clear");
        // R7 deferred reload
        wr(A_LATER, 32'd5, 1'b0);
        rd(A_CNT, 32'd10, "R7 count untouched");
        rd(A_NOW, 32'd5, "R7 reload changed");
        tk(10);
        rd(A_CNT, 32'd0, "R7 counts old period");
        tk(1);
        rd(A_CNT, 32'd5, "R7 new period at reload");
        wr(A_ACK, 32'h0, 1'b0);
        // R12 mask off
        wr(A_MODE, 32'hC2, 1'b0);
        tk(5);
        rd(A_RAW, 32'd1, "R12 raw with mask off");
        rd(A_MSK, 32'd0, "R12 masked zero");
        ck_irq(1'b0, "R12 irq gated");
        wr(A_MODE, 32'hE2, 1'b0);
        rd(A_CNT, 32'd0, "R3 mode write keeps count");
        ck_irq(1'b1, "R12 irq on enable");
        wr(A_ACK, 32'h0, 1'b0);
        // R10 one-shot wins over periodic
        wr(A_NOW, 32'd3, 1'b0);
        wr(A_MODE, 32'hE3, 1'b0);
        tk(3);
        rd(A_RAW, 32'd1, "R10 one-shot fires");
        tk(4);
        rd(A_CNT, 32'd0, "R10 parks at zero");
        wr(A_ACK, 32'h0, 1'b0);
        tk(2);
        rd(A_RAW, 32'd0, "R11 no set while parked");
        wr(A_NOW, 32'd2, 1'b0);
        rd(A_CNT, 32'd2, "R10 restart by load");
        // R8 free-running 32-bit
        wr(A_MODE, 32'h82, 1'b0);
        tk(2);
        rd(A_RAW, 32'd1, "R11 free run hits zero");
        tk(1);
        rd(A_CNT, 32'hFFFF_FFFF, "R8 wide free reload");
        wr(A_ACK, 32'h0, 1'b0);
        // R13 / R8 free-running 16-bit
        wr(A_MODE, 32'h80, 1'b0);
        rd(A_CNT, 32'h0000_FFFF, "R13 upper bits hidden");
        wr(A_NOW, 32'h0005_0002, 1'b0);
        rd(A_CNT, 32'h0000_0002, "R13 narrow load");
        tk(2);
        rd(A_RAW, 32'd1, "R13 narrow zero test");
        tk(1);
        rd(A_CNT, 32'h0000_FFFF, "R8 narrow free reload");
        wr(A_ACK, 32'h0, 1'b0);
        // R5 prescaler
        wr(A_NOW, 32'd100, 1'b0);
        wr(A_MODE, 32'h86, 1'b0);
        tk(15);
        rd(A_CNT, 32'd100, "R5 by16 short");
        tk(1);
        rd(A_CNT, 32'd99, "R5 by16 fires");
        tk(32);
        rd(A_CNT, 32'd97, "R5 by16 steady");
        wr(A_MODE, 32'h8A, 1'b0);
        tk(255);
        rd(A_CNT, 32'd97, "R5 by256 short");
        tk(1);
        rd(A_CNT, 32'd96, "R5 by256 fires");
        wr(A_MODE, 32'h8E, 1'b0);
        tk(1);
        rd(A_CNT, 32'd95, "R5 code 11 by1");
        wr(A_MODE, 32'h86, 1'b0);
        tk(10);
        wr(A_MODE, 32'h86, 1'b0);
        tk(10);
        rd(A_CNT, 32'd95, "R5 restart on mode write");
        tk(6);
        rd(A_CNT, 32'd94, "R5 after restart");
        // R6 load wins over tick
        wr(A_MODE, 32'h82, 1'b0);
        wr(A_NOW, 32'd50, 1'b1);
        rd(A_CNT, 32'd50, "R6 load beats tick");
        // R11 set wins over clear
        wr(A_NOW, 32'd1, 1'b0);
        wr(A_ACK, 32'h0, 1'b1);
        rd(A_CNT, 32'd0, "R11 tick with clear");
        rd(A_RAW, 32'd1, "R11 set beats clear");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule